// File: doc/BRIEF.md
# Receive FIFO with Error Status Accumulator

This block buffers received characters for one serial receive channel. Each stored entry carries an 8-bit character and four error flags. The entry at the read position, called the head, is always shown at the outputs together with its flags. Alongside the buffer, the block keeps a sticky 4-bit summary of the errors it has seen. Software reads this summary to decide whether a block of received data is clean.

The summary can be built in one of two ways. By default, an entry's flags are merged into the summary only when that entry reaches the head. A one-cycle command pulse switches the block so that flags are merged as each character is pushed instead. This gives the earliest warning of a bad character, but it no longer tells which stored character is the bad one. Once selected, the push-time setting stays in force until a device reset or a receiver reset. The block also takes a pulse that clears the summary, and a receiver-reset pulse that discards the buffered data.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset, the block shows empty_o=1, full_o=0, err_status_o=0, and head_data_o and head_flags_o at zero. The head outputs read zero whenever the FIFO is empty.
- R2: The FIFO holds up to 16 entries and delivers them first in, first out. The head outputs show the oldest character and its flags. full_o is high at 16 entries and empty_o is high at 0 entries. The flag bit positions are: bit 3 received break, bit 2 framing error, bit 1 parity error, bit 0 overrun. err_status_o uses the same bit positions.
- R3: In the default mode, an entry's flags are OR-ed into err_status_o on the clock edge at which that entry becomes the head. A flagged entry waiting behind the head leaves the summary unchanged.
- R4: A push_mode_cmd_i pulse takes effect from the next cycle. From then on, the flags of each accepted push are OR-ed into err_status_o on the push edge. The mode persists through clears and pops.
- R5: A clr_err_i pulse clears all four err_status_o bits together on the next edge.
- R6: rx_reset_i empties the FIFO, discards unread entries, clears err_status_o and returns the block to the default mode. It overrides every other input in the same cycle. rst_n has the same effect asynchronously.
- R7: A push while the FIFO is full and no pop is requested drops the incoming character and sets bit 0 (overrun) in the flags of the newest stored entry. In push-time mode, it also sets bit 0 of err_status_o. A push together with a pop on a full FIFO is accepted.
- R8: A pop on an empty FIFO is ignored. A push together with a pop on an empty FIFO stores the character.
- R9: When clr_err_i coincides with a new accumulation in the same cycle, the newly accumulated bits are set after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Store a received character |
| push_data_i | input | 8 | Character to store |
| push_flags_i | input | 4 | Error flags of the character |
| pop_i | input | 1 | Remove the head entry |
| clr_err_i | input | 1 | Clear the error summary |
| rx_reset_i | input | 1 | Receiver reset pulse |
| push_mode_cmd_i | input | 1 | Select push-time accumulation |
| head_data_o | output | 8 | Head character |
| head_flags_o | output | 4 | Head error flags |
| err_status_o | output | 4 | Accumulated error summary |
| empty_o | output | 1 | FIFO empty |
| full_o | output | 1 | FIFO full |

## Verification
Directed sequences place a flagged character behind a clean head. This separates head-arrival accumulation from push-time accumulation, because the summary must stay at zero in the first mode and rise at once in the second. Further directed cases do the following:
- fill the FIFO and overflow it, to show where the overrun flag lands;
- coincide a clear with a head arrival;
- pop an empty FIFO;
- reset the receiver after the mode command, to prove the mode returns to default.

Seeded random traffic then mixes sparse error flags with pushes, pops, clears, mode commands and receiver resets, and is compared every cycle against a queue model in the bench.

// File: rtl/rx_err_fifo.sv
module rx_err_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int FW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic [FW-1:0] push_flags_i,
  input  logic          pop_i,
  input  logic          clr_err_i,
  input  logic          rx_reset_i,
  input  logic          push_mode_cmd_i,
  output logic [DW-1:0] head_data_o,
  output logic [FW-1:0] head_flags_o,
  output logic [FW-1:0] err_status_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = DW + FW;
  localparam int OVR_BIT = 0;
  localparam logic [FW-1:0] OVR_MASK = FW'(1) << OVR_BIT;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [AW:0]   count;
  logic          push_mode;

  logic          pop_ok, push_ok, drop, arrive;
  logic [AW-1:0] next_rd, last_wr;
  logic [FW-1:0] arrive_flags, gained;

  assign empty_o = (count == '0);
  assign full_o  = (count == FULL_CNT);
  assign pop_ok  = pop_i && !empty_o;
  assign push_ok = push_i && (!full_o || pop_ok);
  assign drop    = push_i && !push_ok;
  assign next_rd = rd_ptr + 1'b1;
  assign last_wr = wr_ptr - 1'b1;

  assign head_data_o  = empty_o ? '0 : mem[rd_ptr][DW-1:0];
  assign head_flags_o = empty_o ? '0 : mem[rd_ptr][EW-1:DW];

  always_comb begin
    arrive       = 1'b0;
    arrive_flags = push_flags_i;
    if (empty_o) begin
      arrive = push_ok;
    end else if (pop_ok) begin
      if (count == (AW+1)'(1)) begin
        arrive = push_ok;
      end else begin
        arrive       = 1'b1;
        arrive_flags = mem[next_rd][EW-1:DW];
      end
    end
  end

  assign gained = push_mode
                ? ((push_ok ? push_flags_i : '0) | (drop ? OVR_MASK : '0))
                : (arrive ? arrive_flags : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr       <= '0;
      wr_ptr       <= '0;
      count        <= '0;
      err_status_o <= '0;
      push_mode    <= 1'b0;
    end else if (rx_reset_i) begin
      rd_ptr       <= '0;
      wr_ptr       <= '0;
      count        <= '0;
      err_status_o <= '0;
      push_mode    <= 1'b0;
    end else begin
      if (pop_ok)  rd_ptr <= next_rd;
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      count        <= count + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
      err_status_o <= (clr_err_i ? '0 : err_status_o) | gained;
      if (push_mode_cmd_i) push_mode <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rx_reset_i) begin
      if (push_ok)   mem[wr_ptr] <= {push_flags_i, push_data_i};
      else if (drop) mem[last_wr][DW+OVR_BIT] <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk #(
  parameter int DW = 8,
  parameter int FW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_i,
  input logic          pop_i,
  input logic          clr_err_i,
  input logic          rx_reset_i,
  input logic [DW-1:0] head_data_o,
  input logic [FW-1:0] err_status_o,
  input logic          empty_o,
  input logic          full_o
);
  // R2
  empty_full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty_o && full_o));

  // R6
  rx_reset_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset_i |=> (empty_o && err_status_o == '0));

  // R5
  clr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err_i && !push_i && !pop_i && !rx_reset_i) |=> (err_status_o == '0));

  // R8
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && pop_i && !push_i && !rx_reset_i) |=> empty_o);

  // R7
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !pop_i && !rx_reset_i) |=> (full_o && $stable(head_data_o)));

  // R3
  sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_err_i && !rx_reset_i) |=> ((err_status_o & $past(err_status_o)) == $past(err_status_o)));
endmodule

bind rx_err_fifo rx_err_fifo_chk #(.DW(DW), .FW(FW)) chk_i (
  .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
  .clr_err_i(clr_err_i), .rx_reset_i(rx_reset_i),
  .head_data_o(head_data_o), .err_status_o(err_status_o),
  .empty_o(empty_o), .full_o(full_o)
);

// File: tb/rx_err_fifo_tb_top.sv
module rx_err_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic push_i = 0, pop_i = 0, clr_err_i = 0, rx_reset_i = 0, push_mode_cmd_i = 0;
  logic [7:0] push_data_i = '0;
  logic [3:0] push_flags_i = '0;
  logic [7:0] head_data_o;
  logic [3:0] head_flags_o, err_status_o;
  logic empty_o, full_o;

  int checks = 0, errors = 0;
  logic [11:0] mq[$];
  bit mmode;
  logic [3:0] macc;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_err_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
    .push_flags_i(push_flags_i), .pop_i(pop_i), .clr_err_i(clr_err_i),
    .rx_reset_i(rx_reset_i), .push_mode_cmd_i(push_mode_cmd_i),
    .head_data_o(head_data_o), .head_flags_o(head_flags_o),
    .err_status_o(err_status_o), .empty_o(empty_o), .full_o(full_o)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] model_gain_and_update(bit p, logic [7:0] d, logic [3:0] f, bit po);
    int cnt = mq.size();
    bit pe = po && cnt > 0;
    bit pa = p && (cnt < DEPTH || pe);
    logic [3:0] g = '0;
    if (pe) void'(mq.pop_front());
    if (p && !pa) begin
      mq[mq.size()-1][8] = 1'b1;
      if (mmode) g |= 4'b0001;
    end
    if (pa) begin
      mq.push_back({f, d});
      if (mmode) g |= f;
    end
    if (!mmode && mq.size() > 0 && (pe || cnt == 0)) g |= mq[0][11:8];
    return g;
  endfunction

  task automatic compare(string tag);
    logic [11:0] h = (mq.size() > 0) ? mq[0] : 12'h0;
    chk({tag, " head_data"}, head_data_o, h[7:0]);
    chk({tag, " head_flags"}, head_flags_o, h[11:8]);
    chk({tag, " err_status"}, err_status_o, macc);
    chk({tag, " empty"}, empty_o, mq.size() == 0);
    chk({tag, " full"}, full_o, mq.size() == DEPTH);
  endtask

  task automatic step(bit p, logic [7:0] d, logic [3:0] f, bit po, bit c, bit rr, bit mc, string tag);
    logic [3:0] g;
    push_i = p; push_data_i = d; push_flags_i = f; pop_i = po;
    clr_err_i = c; rx_reset_i = rr; push_mode_cmd_i = mc;
    @(posedge clk);
    if (rr) begin
      mq.delete(); mmode = 0; macc = '0;
    end else begin
      g = model_gain_and_update(p, d, f, po);
      macc = (c ? 4'h0 : macc) | g;
      if (mc) mmode = 1;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    rst_n = 0;
    push_i = 0; pop_i = 0; clr_err_i = 0; rx_reset_i = 0; push_mode_cmd_i = 0;
    repeat (2) @(negedge clk);
    mq.delete(); mmode = 0; macc = '0;
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    do_reset();
    // R1 reset state
    chk("R1 empty", empty_o, 1); chk("R1 full", full_o, 0);
    chk("R1 status", err_status_o, 0); chk("R1 head", head_data_o, 0);

    // R2 ordering
    step(1, 8'h11, 4'h0, 0, 0, 0, 0, "R2");
    step(1, 8'h22, 4'h0, 0, 0, 0, 0, "R2");
    step(0, 8'h00, 4'h0, 1, 0, 0, 0, "R2");
    chk("R2 order", head_data_o, 8'h22);
    step(0, 8'h00, 4'h0, 1, 0, 0, 0, "R2");

    // R3 head-arrival accumulation
    step(1, 8'h31, 4'h0, 0, 0, 0, 0, "R3");
    step(1, 8'h32, 4'h2, 0, 0, 0, 0, "R3");
    chk("R3 waiting behind head", err_status_o, 4'h0);
    step(0, 8'h00, 4'h0, 1, 0, 0, 0, "R3");
    chk("R3 at head", err_status_o, 4'h2);

    // R5 clear
    step(0, 8'h00, 4'h0, 0, 1, 0, 0, "R5");
    chk("R5 cleared", err_status_o, 4'h0);

    // R9 clear with head arrival in the same cycle
    step(0, 8'h00, 4'h0, 1, 0, 0, 0, "R9");
    step(1, 8'h99, 4'h8, 0, 1, 0, 0, "R9");
    chk("R9 new wins", err_status_o, 4'h8);

    // R8 pop on empty, push+pop on empty
    step(0, 8'h00, 4'h0, 1, 1, 0, 0, "R8");
    step(0, 8'h00, 4'h0, 1, 0, 0, 0, "R8");
    chk("R8 ignored", empty_o, 1);
    step(1, 8'h88, 4'h0, 1, 0, 0, 0, "R8");
    chk("R8 stored", head_data_o, 8'h88);

    // R4 push-time mode
    step(0, 8'h00, 4'h0, 0, 0, 0, 1, "R4");
    step(1, 8'h41, 4'h4, 0, 0, 0, 0, "R4");
    chk("R4 immediate", err_status_o, 4'h4);
    step(0, 8'h00, 4'h0, 0, 1, 0, 0, "R4");
    step(1, 8'h42, 4'h2, 0, 0, 0, 0, "R4");
    chk("R4 sticky", err_status_o, 4'h2);

    // R6 receiver reset returns to default mode
    step(0, 8'h00, 4'h0, 0, 0, 1, 0, "R6");
    chk("R6 empty", empty_o, 1);
    step(1, 8'h61, 4'h0, 0, 0, 0, 0, "R6");
    step(1, 8'h62, 4'h2, 0, 0, 0, 0, "R6");
    chk("R6 head mode again", err_status_o, 4'h0);
    step(0, 8'h00, 4'h0, 0, 0, 1, 0, "R6");

    // R7 overflow
    for (int i = 0; i < DEPTH; i++) step(1, 8'(i), 4'h0, 0, 0, 0, 0, "R7");
    chk("R7 full", full_o, 1);
    step(1, 8'hAA, 4'h0, 0, 0, 0, 0, "R7");
    for (int i = 0; i < DEPTH-1; i++) step(0, 8'h00, 4'h0, 1, 0, 0, 0, "R7");
    chk("R7 newest data", head_data_o, DEPTH-1);
    chk("R7 overrun flag", head_flags_o, 4'h1);
    chk("R7 status at head", err_status_o, 4'h1);
    step(0, 8'h00, 4'h0, 0, 0, 1, 0, "R7");

    // random traffic, R2 R3 R4 R5 R7 R8 model comparison
    for (int n = 0; n < 4000; n++) begin
      bit p  = ($urandom % 100) < 55;
      bit po = ($urandom % 100) < 45;
      bit c  = ($urandom % 100) < 5;
      bit rr = ($urandom % 400) == 0;
      bit mc = ($urandom % 300) == 0;
      logic [3:0] f = (($urandom % 8) == 0) ? 4'($urandom) : 4'h0;
      step(p, 8'($urandom), f, po, c, rr, mc, "R2 R3 R4 R7 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule